// File: doc/BRIEF.md
# Line Reset Request Controller

This block drives up to 32 active-low reset lines toward peripheral targets from a small register window on a simple 32-bit register bus. A request register holds one bit per line: a 0 holds that line in reset and a 1 lets it run. The request bit drives the line output directly, one clock edge after the bus write.

A read-only status register tells software when a change has taken effect. Each line has its own settle timer. Its status bit takes the new request value a fixed number of clock cycles after the request changes, which models the reset spreading into the target. Status 0 means the line is held in reset and 1 means it is free. A build-time valid mask lists the lines that exist. Bits outside the mask cannot be set, always read as zero and keep their outputs low. Writes always carry the whole word, so the bus master does a read-modify-write to move a single line.

Top module: `rstc_top`

## Requirements
- R1: After reset, the request register and the status register both read 0, and every line output `line_rst_n` is 0 (in reset).
- R2: A write (`bus_sel`=1, `bus_write`=1) at byte offset 0x000 stores `bus_wdata` ANDed with the valid mask. From the next clock edge on, `line_rst_n[i]` equals request bit i, where 0 means reset is asserted.
- R3: A read (`bus_sel`=1, `bus_write`=0) returns, without a wait state, the request register at offset 0x000, the status register at offset 0x004 and zero at any other offset.
- R4: If a request bit changes at clock edge W and stays put, its status bit keeps its old value up to edge W+SETTLE_CYCLES-1 and holds the new value from edge W+SETTLE_CYCLES on.
- R5: If a request bit changes and then returns to its old value before SETTLE_CYCLES edges have passed, its status bit never changes.
- R6: Bits outside the valid mask (default 0x0FFFFFF8) ignore written ones. They read 0 in both registers and their line outputs stay 0.
- R7: Writes to offset 0x004 or to any offset other than 0x000 leave the request register and the line outputs unchanged.
- R8: Each line has its own timer, so a change on one line neither restarts nor delays the settle count of another line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| bus_sel | input | 1 | Bus access strobe for this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset within the block window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as a read strobe |
| line_rst_n | output | NUM_LINES | Active-low reset output, one per line |

## Verification
The bench checks the status bit on both sides of the settle edge, one cycle before and one cycle after it. A timer that is off by one cycle, or a status that follows the request at once, fails on one side or the other. It sends a one-cycle request pulse and then watches the status for several cycles. A design that lets a started timer run to the end after the request has reverted would show a false completion. It starts two lines a few cycles apart. A shared timer that restarts on any write would make the first line settle late. Writes of all ones, writes to the status offset and writes to unused offsets catch designs that let writes leak into the request register or into bits outside the mask.

// File: rtl/rstc_pkg.sv
package rstc_pkg;

    localparam int unsigned WORD_W = 32;

    typedef logic [WORD_W-1:0] word_t;

    // Register targeted by a bus access.
    typedef enum logic [1:0] {
        TGT_NONE,
        TGT_REQUEST,
        TGT_STATUS
    } tgt_e;

    // Mask with the lowest n bits set.
    function automatic word_t low_ones(input int unsigned n);
        word_t m;
        m = '0;
        for (int unsigned i = 0; i < WORD_W; i++) begin
            if (i < n) m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/rstc_line.sv
module rstc_line #(
    parameter int unsigned SETTLE_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    output logic stat_o
);

    localparam int unsigned CNT_W = (SETTLE_CYCLES < 2) ? 1 : $clog2(SETTLE_CYCLES);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE_CYCLES - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             stat;
    } trk_t;

    trk_t trk_d, trk_q;

    always_comb begin
        trk_d = trk_q;
        if (req_i == trk_q.stat) begin
            // Settled, or the request went back: drop any partial count.
            trk_d.cnt = '0;
        end else if (trk_q.cnt == LAST) begin
            trk_d.stat = req_i;
            trk_d.cnt  = '0;
        end else begin
            trk_d.cnt = trk_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trk_q <= '0;
        else        trk_q <= trk_d;
    end

    assign stat_o = trk_q.stat;

    // R4: status only moves on the edge that ends a full count.
    a_r4_move_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(trk_q.stat) |-> ($past(trk_q.cnt) == LAST));

    // R5: a request equal to the status keeps the status unchanged.
    a_r5_hold_when_equal: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i == trk_q.stat) |=> $stable(trk_q.stat));

    // R4: a change of status always takes the request value.
    a_r4_takes_request: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(trk_q.stat) |-> (trk_q.stat == $past(req_i)));

endmodule

// File: rtl/rstc_regif.sv
module rstc_regif
    import rstc_pkg::*;
#(
    parameter int unsigned ADDR_W   = 8,
    parameter word_t       VALID    = 32'h0FFF_FFF8,
    parameter logic [ADDR_W-1:0] REQ_OFF  = 'h0,
    parameter logic [ADDR_W-1:0] STAT_OFF = 'h4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  word_t             bus_wdata,
    input  word_t             stat_i,
    output word_t             req_o,
    output word_t             bus_rdata
);

    typedef struct packed {
        word_t req;
    } regs_t;

    regs_t regs_d, regs_q;
    tgt_e  tgt;

    always_comb begin
        if (!bus_sel)                  tgt = TGT_NONE;
        else if (bus_addr == REQ_OFF)  tgt = TGT_REQUEST;
        else if (bus_addr == STAT_OFF) tgt = TGT_STATUS;
        else                           tgt = TGT_NONE;
    end

    always_comb begin
        regs_d = regs_q;
        if (bus_write && tgt == TGT_REQUEST) begin
            regs_d.req = bus_wdata & VALID;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        bus_rdata = '0;
        if (!bus_write) begin
            unique case (tgt)
                TGT_REQUEST: bus_rdata = regs_q.req;
                TGT_STATUS:  bus_rdata = stat_i & VALID;
                default:     bus_rdata = '0;
            endcase
        end
    end

    assign req_o = regs_q.req;

    // R2: a request write lands in the register on the next edge.
    a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_write && bus_addr == REQ_OFF) |=>
            (regs_q.req == ($past(bus_wdata) & VALID)));

    // R6: bits outside the mask are never set.
    a_r6_no_ghost_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.req & ~VALID) == '0);

    // R7: writes elsewhere leave the request untouched.
    a_r7_other_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_write && bus_addr != REQ_OFF) |=> $stable(regs_q.req));

endmodule

// File: rtl/rstc_top.sv
module rstc_top
    import rstc_pkg::*;
#(
    parameter int unsigned NUM_LINES     = 32,
    parameter word_t       VALID_MASK    = 32'h0FFF_FFF8,
    parameter int unsigned SETTLE_CYCLES = 4,
    parameter int unsigned ADDR_W        = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_sel,
    input  logic                 bus_write,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    output logic [NUM_LINES-1:0] line_rst_n
);

    localparam word_t EFF_MASK = VALID_MASK & low_ones(NUM_LINES);
    localparam logic [ADDR_W-1:0] REQ_OFF  = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] STAT_OFF = ADDR_W'(4);

    word_t req_w;
    word_t stat_w;

    rstc_regif #(
        .ADDR_W   (ADDR_W),
        .VALID    (EFF_MASK),
        .REQ_OFF  (REQ_OFF),
        .STAT_OFF (STAT_OFF)
    ) i_regif (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .stat_i    (stat_w),
        .req_o     (req_w),
        .bus_rdata (bus_rdata)
    );

    for (genvar g = 0; g < WORD_W; g++) begin : g_line
        if (EFF_MASK[g]) begin : g_live
            rstc_line #(
                .SETTLE_CYCLES (SETTLE_CYCLES)
            ) i_line (
                .clk    (clk),
                .rst_n  (rst_n),
                .req_i  (req_w[g]),
                .stat_o (stat_w[g])
            );
        end else begin : g_absent
            assign stat_w[g] = 1'b0;
        end
    end

    assign line_rst_n = req_w[NUM_LINES-1:0];

    // R7: line outputs move only after a request write.
    a_r7_outputs_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && bus_write && bus_addr == REQ_OFF) |=> $stable(line_rst_n));

    // R3: reads at unused offsets return zero.
    a_r3_unused_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_write && bus_addr != REQ_OFF && bus_addr != STAT_OFF)
            |-> (bus_rdata == '0));

endmodule

// File: tb/test_rstc_top.sv
module test_rstc_top;

    localparam logic [31:0] MASK = 32'h0FFF_FFF8;
    localparam int unsigned SETTLE = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_write = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] line_rst_n;

    int total = 0;
    int bad = 0;
    logic [31:0] cur = '0;

    always #5 clk = ~clk;

    rstc_top #(
        .NUM_LINES     (32),
        .VALID_MASK    (MASK),
        .SETTLE_CYCLES (SETTLE),
        .ADDR_W        (8)
    ) i_rstc_top (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_sel    (bus_sel),
        .bus_write  (bus_write),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .line_rst_n (line_rst_n)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_write = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(8'h00, v); chk("R1 request after reset", v, 32'h0);
        rd(8'h04, v); chk("R1 status after reset", v, 32'h0);
        chk("R1 lines after reset", line_rst_n, 32'h0);
    endtask

    task automatic t_release_all();
        logic [31:0] v;
        wr(8'h00, 32'hFFFF_FFFF);
        cur = MASK;
        rd(8'h00, v); chk("R6 request masked", v, MASK);
        chk("R2 lines follow request", line_rst_n, MASK);
        rd(8'h04, v); chk("R4 status not yet moved", v, 32'h0);
        step(SETTLE - 1);
        rd(8'h04, v); chk("R4 status one cycle before settle", v, 32'h0);
        step(1);
        rd(8'h04, v); chk("R4 status at settle edge", v, MASK);
        rd(8'h08, v); chk("R3 unused offset reads zero", v, 32'h0);
    endtask

    task automatic t_assert_one();
        logic [31:0] v;
        wr(8'h00, cur & ~32'h8);
        step(SETTLE - 1);
        rd(8'h04, v); chk("R4 assert, before settle", v, cur);
        step(1);
        cur = cur & ~32'h8;
        rd(8'h04, v); chk("R4 assert, at settle", v, cur);
        chk("R2 line 3 held in reset", line_rst_n, cur);
    endtask

    task automatic t_glitch();
        logic [31:0] v;
        wr(8'h00, cur & ~32'h20);
        wr(8'h00, cur);
        for (int i = 0; i < 6; i++) begin
            rd(8'h04, v); chk("R5 short pulse hidden in status", v, cur);
            step(1);
        end
        chk("R2 lines back after pulse", line_rst_n, cur);
    endtask

    task automatic t_ignored();
        logic [31:0] v;
        wr(8'h04, 32'h0);
        wr(8'h0C, 32'h0);
        wr(8'h10, 32'hFFFF_FFFF);
        rd(8'h00, v); chk("R7 request unchanged", v, cur);
        chk("R7 lines unchanged", line_rst_n, cur);
        step(SETTLE + 1);
        rd(8'h04, v); chk("R7 status unchanged", v, cur);
    endtask

    task automatic t_independent();
        logic [31:0] v;
        logic [31:0] a;
        logic [31:0] b;
        a = cur & ~32'h400;
        b = a & ~32'h0010_0000;
        wr(8'h00, a);           // edge W
        step(2);
        wr(8'h00, b);           // edge W+3
        rd(8'h04, v); chk("R8 line 10 not yet settled", v, cur);
        step(1);                // W+4
        rd(8'h04, v); chk("R8 line 10 settles on its own count", v, a);
        step(2);                // W+6
        rd(8'h04, v); chk("R8 line 20 still counting", v, a);
        step(1);                // W+7
        rd(8'h04, v); chk("R8 line 20 settles", v, b);
        cur = b;
    endtask

    task automatic t_invalid_only();
        logic [31:0] v;
        wr(8'h00, ~MASK);
        rd(8'h00, v); chk("R6 unmasked ones dropped", v, 32'h0);
        chk("R6 lines all in reset", line_rst_n, 32'h0);
        step(SETTLE);
        rd(8'h04, v); chk("R6 status all zero", v, 32'h0);
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_release_all();
        t_assert_one();
        t_glitch();
        t_ignored();
        t_independent();
        t_invalid_only();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1_000_000;
        total++;
        bad++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule